// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Routing

This block sits beside a core's control-status state and decides, every cycle, whether a trap is to be taken. An exception presented by the pipeline always wins. Otherwise the block looks at the pending interrupt lines. It filters them through the current privilege and the global enables of the two privileged levels, then through the interrupt delegation mask. From what survives it picks one interrupt by a fixed class priority. It then chooses the handling level (machine or supervisor), forms the cause word and computes the handler address.

The take decision, cause, target level, handler address and post-trap enable values are produced combinationally from the inputs of the same cycle. The trap record of each level holds the cause, the saved PC, the previous enable and the previous privilege. It is written at the clock edge on which a trap to that level is taken, and it is held at all other edges. The core is expected to feed the returned enables and the target privilege back into its own state. Privilege is encoded 0 for user, 1 for supervisor and 3 for machine.

Top module: `trap_arbiter`

## Requirements
- R1: An interrupt that is not delegated is enabled when the current privilege is below machine, or when the privilege is machine and `m_ie` is 1.
- R2: Delegated interrupts are looked at only when no enabled non-delegated interrupt is pending. They are enabled when the privilege is user, or when it is supervisor and `s_ie` is 1.
- R3: Among the enabled interrupts, one class is chosen in this order: bits 12 and above first, then external (bits 9 and 11), then software (bits 1 and 3), then timer (bits 5 and 7). Inside the chosen class the lowest set bit wins, so bit 9 beats bit 11.
- R4: `trap_cause` carries the winning bit index or the exception code in its low `CODE_W` bits. Its top bit is 1 for an interrupt and 0 for an exception, and all other bits are 0.
- R5: A trap goes to supervisor (`trap_priv` = 1) when the current privilege is user or supervisor and the delegation bit at the code's index is 1. Exceptions use `exc_deleg` and interrupts use `irq_deleg`. All other traps go to machine (`trap_priv` = 3).
- R6: On a supervisor trap, `trap_pc` is `s_tvec` with bits 1:0 cleared. At the clock edge, `s_cause_q` takes the cause, `s_epc_q` takes `epc_in`, `s_pie_q` takes `s_ie` and `s_pp_q` takes bit 0 of the privilege. `nxt_s_ie` is 0.
- R7: On a machine trap, `trap_pc` is `m_tvec` with bits 1:0 cleared. When `m_tvec[0]` is 1 and the trap is an interrupt, 4 times the cause code is added.
- R8: On a machine trap, `m_cause_q`, `m_epc_q`, `m_pie_q` (takes `m_ie`) and `m_pp_q` (takes the privilege) are written at the clock edge, and `nxt_m_ie` is 0.
- R9: While `dbg_halt` is 1, no interrupt is taken, but an exception still is. An exception takes precedence over any pending interrupt.
- R10: Pending bits 0, 2, 4, 6, 8 and 10 belong to no class. They never cause a trap, and they never hide a delegated interrupt.
- R11: Reset clears every recorded field. With no trap, every recorded field holds its value, `nxt_m_ie`/`nxt_s_ie` follow `m_ie`/`s_ie`, and `trap_priv` equals `cur_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| dbg_halt | input | 1 | Halt indication; masks interrupts |
| irq_pend | input | 2**CODE_W | Pending interrupt lines |
| irq_deleg | input | 2**CODE_W | Interrupt delegation mask |
| exc_deleg | input | 2**CODE_W | Exception delegation mask |
| exc_valid | input | 1 | An exception is raised this cycle |
| exc_code | input | CODE_W | Exception code |
| epc_in | input | XLEN | PC to save on a trap |
| m_tvec | input | XLEN | Machine handler base; bit 0 selects vectored mode |
| s_tvec | input | XLEN | Supervisor handler base |
| trap_take | output | 1 | A trap is taken this cycle |
| trap_priv | output | 2 | Privilege after this cycle |
| trap_cause | output | XLEN | Cause word |
| trap_pc | output | XLEN | Handler address |
| nxt_m_ie | output | 1 | Machine enable after this cycle |
| nxt_s_ie | output | 1 | Supervisor enable after this cycle |
| m_cause_q | output | XLEN | Recorded machine cause |
| m_epc_q | output | XLEN | Recorded machine PC |
| m_pie_q | output | 1 | Recorded machine previous enable |
| m_pp_q | output | 2 | Recorded machine previous privilege |
| s_cause_q | output | XLEN | Recorded supervisor cause |
| s_epc_q | output | XLEN | Recorded supervisor PC |
| s_pie_q | output | 1 | Recorded supervisor previous enable |
| s_pp_q | output | 1 | Recorded supervisor previous privilege |

## Verification
Interrupts are first driven one line at a time at each privilege with the enables swept. This separates the level gating from the priority logic. Mixed pending sets follow: timer plus software plus external, both external bits, a high custom bit plus external, and delegated plus non-delegated lines. Each set exposes one ordering decision, including the lowest-bit rule and the precedence of the machine level over the supervisor level. Exceptions are sent with and without delegation from every level, with vectored mode on, and while halted. This shows which mask routes each kind of trap and that vectoring applies to interrupts only. Unclassified bits and idle cycles confirm that the recorded state is left alone.

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cur_priv,
  input  logic                     m_ie,
  input  logic                     s_ie,
  input  logic                     dbg_halt,
  input  logic [(1<<CODE_W)-1:0]   irq_pend,
  input  logic [(1<<CODE_W)-1:0]   irq_deleg,
  input  logic [(1<<CODE_W)-1:0]   exc_deleg,
  input  logic                     exc_valid,
  input  logic [CODE_W-1:0]        exc_code,
  input  logic [XLEN-1:0]          epc_in,
  input  logic [XLEN-1:0]          m_tvec,
  input  logic [XLEN-1:0]          s_tvec,
  output logic                     trap_take,
  output logic [1:0]               trap_priv,
  output logic [XLEN-1:0]          trap_cause,
  output logic [XLEN-1:0]          trap_pc,
  output logic                     nxt_m_ie,
  output logic                     nxt_s_ie,
  output logic [XLEN-1:0]          m_cause_q,
  output logic [XLEN-1:0]          m_epc_q,
  output logic                     m_pie_q,
  output logic [1:0]               m_pp_q,
  output logic [XLEN-1:0]          s_cause_q,
  output logic [XLEN-1:0]          s_epc_q,
  output logic                     s_pie_q,
  output logic                     s_pp_q
);
  localparam int N = 1 << CODE_W;
  localparam logic [N-1:0] ONE     = N'(1);
  localparam logic [N-1:0] CLS_EXT = (ONE << 9) | (ONE << 11);
  localparam logic [N-1:0] CLS_SW  = (ONE << 1) | (ONE << 3);
  localparam logic [N-1:0] CLS_TM  = (ONE << 5) | (ONE << 7);
  localparam logic [N-1:0] CLS_HI  = ~N'(0) << 12;
  localparam logic [N-1:0] LEGAL   = CLS_HI | CLS_EXT | CLS_SW | CLS_TM;

  function automatic logic [CODE_W-1:0] low_idx(input logic [N-1:0] v);
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) low_idx = CODE_W'(i);
  endfunction

  logic [N-1:0]      pend_ok, en_m, en_s, en_sel, grp;
  logic              m_lvl_ok, s_lvl_ok, irq_hit, is_int, dbit, to_s;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   m_base, s_base, vec_off;

  assign pend_ok  = irq_pend & LEGAL;
  assign m_lvl_ok = (cur_priv != 2'd3) || m_ie;
  assign s_lvl_ok = (cur_priv == 2'd0) || ((cur_priv == 2'd1) && s_ie);
  assign en_m     = pend_ok & ~irq_deleg & {N{m_lvl_ok}};
  assign en_s     = pend_ok &  irq_deleg & {N{s_lvl_ok}};
  assign en_sel   = dbg_halt ? '0 : ((|en_m) ? en_m : en_s);

  always_comb begin
    if      (|(en_sel & CLS_HI))  grp = en_sel & CLS_HI;
    else if (|(en_sel & CLS_EXT)) grp = en_sel & CLS_EXT;
    else if (|(en_sel & CLS_SW))  grp = en_sel & CLS_SW;
    else                          grp = en_sel & CLS_TM;
  end

  assign irq_hit   = |grp;
  assign is_int    = !exc_valid && irq_hit;
  assign trap_take = exc_valid || irq_hit;
  assign code      = exc_valid ? exc_code : low_idx(grp);
  assign dbit      = exc_valid ? exc_deleg[code] : irq_deleg[code];
  assign to_s      = trap_take && (cur_priv <= 2'd1) && dbit;

  assign trap_cause = {is_int, {(XLEN-1-CODE_W){1'b0}}, code};
  assign m_base     = {m_tvec[XLEN-1:2], 2'b00};
  assign s_base     = {s_tvec[XLEN-1:2], 2'b00};
  assign vec_off    = {{(XLEN-CODE_W-2){1'b0}}, code, 2'b00};
  assign trap_pc    = to_s ? s_base : (m_base + ((m_tvec[0] && is_int) ? vec_off : '0));
  assign trap_priv  = !trap_take ? cur_priv : (to_s ? 2'd1 : 2'd3);
  assign nxt_m_ie   = (trap_take && !to_s) ? 1'b0 : m_ie;
  assign nxt_s_ie   = to_s ? 1'b0 : s_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause_q <= '0;
      m_epc_q   <= '0;
      m_pie_q   <= 1'b0;
      m_pp_q    <= 2'd0;
      s_cause_q <= '0;
      s_epc_q   <= '0;
      s_pie_q   <= 1'b0;
      s_pp_q    <= 1'b0;
    end else if (trap_take) begin
      if (to_s) begin
        s_cause_q <= trap_cause;
        s_epc_q   <= epc_in;
        s_pie_q   <= s_ie;
        s_pp_q    <= cur_priv[0];
      end else begin
        m_cause_q <= trap_cause;
        m_epc_q   <= epc_in;
        m_pie_q   <= m_ie;
        m_pp_q    <= cur_priv;
      end
    end
  end
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cur_priv,
  input logic            m_ie,
  input logic            s_ie,
  input logic            dbg_halt,
  input logic            exc_valid,
  input logic [XLEN-1:0] epc_in,
  input logic            trap_take,
  input logic [1:0]      trap_priv,
  input logic [XLEN-1:0] trap_cause,
  input logic            nxt_m_ie,
  input logic            nxt_s_ie,
  input logic [XLEN-1:0] m_cause_q,
  input logic [XLEN-1:0] m_epc_q,
  input logic            m_pie_q,
  input logic [1:0]      m_pp_q,
  input logic [XLEN-1:0] s_cause_q,
  input logic [XLEN-1:0] s_epc_q,
  input logic            s_pie_q,
  input logic            s_pp_q
);
  assert_halt_masks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt && !exc_valid |-> !trap_take);

  assert_exc_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> trap_take && !trap_cause[XLEN-1]);

  assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && !exc_valid |-> trap_cause[XLEN-1]);

  assert_sup_low_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_priv == 2'd1 |-> cur_priv <= 2'd1);

  assert_sup_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_priv == 2'd1 |=> s_epc_q == $past(epc_in) &&
      s_pie_q == $past(s_ie) && s_pp_q == $past(cur_priv[0]) &&
      s_cause_q == $past(trap_cause));

  assert_sup_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_priv == 2'd1 |-> !nxt_s_ie && nxt_m_ie == m_ie);

  assert_mach_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_priv == 2'd3 |=> m_epc_q == $past(epc_in) &&
      m_pie_q == $past(m_ie) && m_pp_q == $past(cur_priv) &&
      m_cause_q == $past(trap_cause));

  assert_mach_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_priv == 2'd3 |-> !nxt_m_ie);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_take |=> $stable(m_cause_q) && $stable(s_cause_q) &&
      $stable(m_epc_q) && $stable(s_epc_q));
endmodule

bind trap_arbiter trap_arbiter_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/test_trap_arbiter.sv
`timescale 1ns/1ps
module test_trap_arbiter;
  localparam int XLEN = 32;
  localparam int CW   = 4;
  localparam int N    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] d_priv; logic d_mie, d_sie, d_halt, d_exv;
  logic [N-1:0] d_pend, d_ideleg, d_edeleg; logic [CW-1:0] d_exc;
  logic [XLEN-1:0] d_epc, d_mtvec, d_stvec;
  logic [1:0] b_priv; logic b_mie, b_sie, b_halt, b_exv;
  logic [N-1:0] b_pend, b_ideleg, b_edeleg; logic [CW-1:0] b_exc;
  logic [XLEN-1:0] b_epc, b_mtvec, b_stvec;

  logic take, nmie, nsie, mpie, spie, spp; logic [1:0] tpriv, mpp;
  logic [XLEN-1:0] cause, pc, mcause, mepc, scause, sepc;

  trap_arbiter #(.XLEN(XLEN), .CODE_W(CW)) i_trap_arbiter (
    .clk(clk), .rst_n(rst_n), .cur_priv(d_priv), .m_ie(d_mie), .s_ie(d_sie),
    .dbg_halt(d_halt), .irq_pend(d_pend), .irq_deleg(d_ideleg), .exc_deleg(d_edeleg),
    .exc_valid(d_exv), .exc_code(d_exc), .epc_in(d_epc), .m_tvec(d_mtvec),
    .s_tvec(d_stvec), .trap_take(take), .trap_priv(tpriv), .trap_cause(cause),
    .trap_pc(pc), .nxt_m_ie(nmie), .nxt_s_ie(nsie), .m_cause_q(mcause),
    .m_epc_q(mepc), .m_pie_q(mpie), .m_pp_q(mpp), .s_cause_q(scause),
    .s_epc_q(sepc), .s_pie_q(spie), .s_pp_q(spp));

  typedef struct {
    string req; logic take; logic [1:0] priv; logic [XLEN-1:0] cause, pc;
    logic nmie, nsie; logic [XLEN-1:0] mc, me, sc, se; logic mpie, spie, spp; logic [1:0] mpp;
  } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  logic [XLEN-1:0] em_c = 0, em_e = 0, es_c = 0, es_e = 0;
  logic em_pie = 0, es_pie = 0, es_pp = 0; logic [1:0] em_pp = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cls(input int i);
    if (i >= 12) return 0;
    if (i == 9 || i == 11) return 1;
    if (i == 1 || i == 3) return 2;
    if (i == 5 || i == 7) return 3;
    return 4;
  endfunction

  task automatic step(input string req);
    exp_t e; int win, best; logic mlvl, slvl, anym, cand, isint, dbit, to_s; logic [CW-1:0] code;
    @(negedge clk);
    d_priv = b_priv; d_mie = b_mie; d_sie = b_sie; d_halt = b_halt; d_exv = b_exv;
    d_pend = b_pend; d_ideleg = b_ideleg; d_edeleg = b_edeleg; d_exc = b_exc;
    d_epc = b_epc; d_mtvec = b_mtvec; d_stvec = b_stvec;
    mlvl = (b_priv != 2'd3) || b_mie;
    slvl = (b_priv == 2'd0) || (b_priv == 2'd1 && b_sie);
    anym = 1'b0;
    for (int i = 0; i < N; i++)
      if (b_pend[i] && cls(i) < 4 && !b_ideleg[i] && mlvl) anym = 1'b1;
    win = -1; best = 4;
    for (int i = 0; i < N; i++) begin
      cand = b_pend[i] && (anym ? (!b_ideleg[i] && mlvl) : (b_ideleg[i] && slvl));
      if (cand && cls(i) < best) begin win = i; best = cls(i); end
    end
    if (b_halt) win = -1;
    e.req = req;
    e.take = b_exv || (win >= 0);
    isint = !b_exv && (win >= 0);
    code = b_exv ? b_exc : CW'(win);
    dbit = b_exv ? b_edeleg[code] : b_ideleg[code];
    to_s = e.take && (b_priv <= 2'd1) && dbit;
    e.cause = 0; e.cause[CW-1:0] = code; e.cause[XLEN-1] = isint;
    e.pc = to_s ? (b_stvec & ~32'h3) :
           ((b_mtvec & ~32'h3) + ((b_mtvec[0] && isint) ? 32'(code) * 4 : 32'h0));
    e.priv = !e.take ? b_priv : (to_s ? 2'd1 : 2'd3);
    e.nmie = (e.take && !to_s) ? 1'b0 : b_mie;
    e.nsie = to_s ? 1'b0 : b_sie;
    if (e.take && to_s) begin es_c = e.cause; es_e = b_epc; es_pie = b_sie; es_pp = b_priv[0]; end
    else if (e.take) begin em_c = e.cause; em_e = b_epc; em_pie = b_mie; em_pp = b_priv; end
    e.mc = em_c; e.me = em_e; e.mpie = em_pie; e.mpp = em_pp;
    e.sc = es_c; e.se = es_e; e.spie = es_pie; e.spp = es_pp;
    q.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.req, "take", take, e.take);
        if (e.take) begin
          chk(e.req, "cause", cause, e.cause);
          chk(e.req, "pc", pc, e.pc);
        end
        chk(e.req, "priv", tpriv, e.priv);
        chk(e.req, "nxt_ie", {nmie, nsie}, {e.nmie, e.nsie});
        chk(e.req, "m_record", {mcause, mepc, mpie, mpp}, {e.mc, e.me, e.mpie, e.mpp});
        chk(e.req, "s_record", {scause, sepc, spie, spp}, {e.sc, e.se, e.spie, e.spp});
      end
    end
  end

  task automatic irq(input logic [N-1:0] p, input logic [N-1:0] dl, input logic [1:0] pr,
                     input logic mi, input logic si);
    b_pend = p; b_ideleg = dl; b_priv = pr; b_mie = mi; b_sie = si; b_exv = 1'b0;
    b_epc = b_epc + 32'h4;
  endtask

  initial begin
    b_priv = 0; b_mie = 0; b_sie = 0; b_halt = 0; b_exv = 0; b_pend = 0; b_ideleg = 0;
    b_edeleg = 0; b_exc = 0; b_epc = 32'h8000_0000; b_mtvec = 32'h0000_1002; b_stvec = 32'h0000_2003;
    d_priv = 0; d_mie = 0; d_sie = 0; d_halt = 0; d_exv = 0; d_pend = 0; d_ideleg = 0;
    d_edeleg = 0; d_exc = 0; d_epc = 0; d_mtvec = 0; d_stvec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset m_record", {mcause, mepc, mpie, mpp}, 0);
    chk("R11", "reset s_record", {scause, sepc, spie, spp}, 0);

    irq(16'h0080, 0, 2'd0, 0, 0); step("R1 timer from user");
    irq(16'h0080, 0, 2'd3, 0, 0); step("R1 machine mie=0 blocked");
    irq(16'h0080, 0, 2'd3, 1, 0); step("R1 machine mie=1");
    b_mtvec = 32'h0000_1001;
    irq(16'h0080, 0, 2'd1, 0, 0); step("R7 vectored timer");
    irq(16'h0888, 0, 2'd0, 0, 0); step("R3 external over sw and timer");
    irq(16'h0088, 0, 2'd0, 0, 0); step("R3 software over timer");
    irq(16'h0a00, 0, 2'd3, 1, 0); step("R3 bit9 over bit11");
    irq(16'h3800, 0, 2'd0, 0, 0); step("R3 high class first");
    b_mtvec = 32'h0000_1000;
    irq(16'h0020, 16'h0222, 2'd1, 1, 1); step("R6 delegated timer to supervisor");
    irq(16'h0020, 16'h0222, 2'd1, 1, 0); step("R2 supervisor sie=0 blocked");
    irq(16'h0020, 16'h0222, 2'd0, 0, 0); step("R2 user takes delegated");
    irq(16'h0020, 16'h0222, 2'd3, 1, 1); step("R2 machine ignores delegated");
    irq(16'h00a0, 16'h0222, 2'd1, 1, 1); step("R2 machine level first");
    irq(16'h00a0, 16'h0222, 2'd3, 0, 1); step("R2 masked machine lets nothing");
    irq(16'h0555, 0, 2'd0, 1, 1); step("R10 unclassified bits ignored");
    irq(16'h0025, 16'h0222, 2'd0, 1, 1); step("R10 unclassified does not hide delegated");
    irq(16'h0000, 0, 2'd3, 1, 1); step("R11 idle holds");
    b_halt = 1;
    irq(16'h0880, 0, 2'd0, 1, 1); step("R9 halt masks interrupt");
    b_exv = 1; b_exc = 4'd2; b_epc = 32'h8000_0100; step("R9 exception while halted");
    b_halt = 0; b_mtvec = 32'h0000_1001;
    b_edeleg = 16'h0004;
    irq(16'h0800, 0, 2'd0, 1, 1); b_exv = 1; b_exc = 4'd2; step("R5 delegated exception over irq");
    irq(0, 0, 2'd3, 1, 1); b_exv = 1; b_exc = 4'd2; step("R5 machine keeps delegated exception");
    irq(0, 0, 2'd1, 1, 1); b_exv = 1; b_exc = 4'd8; step("R7 undelegated exception not vectored");
    irq(0, 16'h0004, 2'd0, 1, 1); b_edeleg = 0; b_exv = 1; b_exc = 4'd2;
    step("R5 exception uses exception mask");
    b_edeleg = 16'hffff;
    irq(16'h0002, 16'h0002, 2'd0, 1, 0); step("R6 software to supervisor from user");
    irq(0, 0, 2'd1, 1, 1); step("R11 idle after supervisor trap");
    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule